// File: doc/BRIEF.md
# Serial Shift Engine

This block is the hardware core of a synchronous serial port that leaves all framing to software. It has one shift register that both receives and sends data. A buffer register takes a copy of each finished byte. A small edge counter marks the end of each byte. Software sets the mode, preloads and reads the registers, and services the two interrupt outputs. It does this through a plain write port with a 2-bit address. Every register value is also brought out on its own output port, so it can be read at any time.

The engine has two wiring modes. In three-wire mode it uses a push-pull data output, a data input and a clock that it either drives or follows. In two-wire mode data and clock are open-drain lines, shown here as "pull low" enables. This mode adds a detector for the bus start condition and a clock-hold that stretches the bus. The bit clock comes from the clock pin, a timer compare pulse, or a software strobe. The address map is:

- 0: shift register.
- 1: status. Bits [3:0] hold the counter value. Writing 1 to bit 6 clears the overflow flag, and writing 1 to bit 7 clears the start flag.
- 2: control.
- 3: strobe. Any write to this address is one strobe.

Top module: `ssc_top`

## Requirements
- R1: After reset the following are all 0: the shift register, the buffer, the counter, both flags, both interrupts and every pin output.
- R2: On each rising edge of the active clock the shift register shifts left by one and takes the selected data input into bit 0. A write to address 0 loads the register and wins over a shift in the same cycle.
- R3: While the active clock level is low, the data pin follows the register MSB. While the level is high, the pin holds the value it had at the rising edge, so the output changes only on falling edges.
- R4: In three-wire mode (control bit 0 = 0), `dout_o` carries the data pin and `sda_pull_o` is 0. In two-wire mode (bit 0 = 1), `dout_o` is 0, `sda_pull_o` is the inverse of the data pin, and data is sampled from `sda_i` instead of `din_i`.
- R5: The counter increments on every rising and falling edge of the active clock. When it passes from 15 to 0, the overflow flag sets and the buffer takes the shift register's value as it stands after that edge. `irq_ovf_o` is high while the flag is set and control bit 3 is 1.
- R6: Control bits [2:1] pick the clock source: 0 is the clock pin, 1 is timer pulses on `tmr_match_i`, and 2 or 3 is strobe writes. Timer pulses have no effect unless the timer source is chosen, and strobes have no effect unless a strobe source is chosen.
- R7: With the timer or strobe source, each pulse or strobe toggles the internal clock level. In three-wire mode this level is driven on `sclk_o`. In two-wire mode `sclk_pull_o` pulls the line low while the level is low.
- R8: A write to address 1 sets the counter to bits [3:0] and clears each flag whose clear bit (6 or 7) is 1. It wins over a clock edge or start condition in the same cycle.
- R9: In two-wire mode, a fall of `sda_i` while `sclk_i` is high sets the start flag and clears the counter. A fall of `sda_i` while `sclk_i` is low does neither. `irq_start_o` is high while the flag is set and control bit 4 is 1.
- R10: In two-wire mode, `sclk_pull_o` holds the clock low while the start flag is set. It also holds the clock low while the overflow flag is set and control bit 5 is 1. The hold ends when software clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| tmr_match_i | input | 1 | Timer compare pulse, one cycle wide |
| sclk_i | input | 1 | Clock line level as read from the pin |
| din_i | input | 1 | Three-wire data input |
| sda_i | input | 1 | Two-wire data line level |
| sclk_o | output | 1 | Three-wire driven clock level |
| sclk_pull_o | output | 1 | Two-wire clock pull-low enable |
| dout_o | output | 1 | Three-wire data output |
| sda_pull_o | output | 1 | Two-wire data pull-low enable |
| data_o | output | 8 | Shift register value |
| buf_o | output | 8 | Buffer register value |
| cnt_o | output | 4 | Edge counter value |
| ovf_o | output | 1 | Overflow flag |
| start_o | output | 1 | Start flag |
| irq_ovf_o | output | 1 | Overflow interrupt |
| irq_start_o | output | 1 | Start interrupt |

## Verification
The assertions assume that the pin levels are already synchronous to `clk` and stay stable for at least one clock between changes. They also assume that a timer pulse lasts exactly one cycle and that only one register address is written per cycle. The stimulus changes every pin and the write port only at the falling edge of `clk`. It holds each clock-pin level for two cycles and never issues two writes to the same cycle. The one deliberate collision it creates is a timer pulse together with a status write, which exercises the write-wins rule.

// File: rtl/ssc_pkg.sv
// Shared types and address map for the serial shift engine.
package ssc_pkg;

    typedef enum logic [1:0] {
        SRC_PIN        = 2'd0,
        SRC_TIMER      = 2'd1,
        SRC_STROBE     = 2'd2,
        SRC_STROBE_ALT = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic     hold_ovf;
        logic     start_ie;
        logic     ovf_ie;
        clk_src_e src;
        logic     two_wire;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_STRB = 2'd3;

endpackage

// File: rtl/ssc_clkgen.sv
// Bit-clock level tracker. It follows the pin level in pin mode and toggles
// on each tick otherwise, then reports the rising and falling edges.
// Assumes pin_i is already synchronous to clk.
module ssc_clkgen (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel_i,
    input  logic pin_i,
    input  logic tick_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic lvl_q;
    logic lvl_nxt;

    // Next clock level, taken from the pin or from the toggle.
    always_comb begin
        lvl_nxt = ext_sel_i ? pin_i : (lvl_q ^ tick_i);
    end

    // Register the level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_nxt;
    end

    assign lvl_o  = lvl_q;
    assign rise_o = lvl_nxt & ~lvl_q;
    assign fall_o = ~lvl_nxt & lvl_q;

    a_r7_tick_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel_i && tick_i) |=> (lvl_o != $past(lvl_o)));

endmodule

// File: rtl/ssc_shifter.sv
// Shift register, byte buffer and the output latch that is transparent
// while the clock is low. Assumes that at most one of wr_i and rise_i
// matters per cycle, and that wr_i wins.
module ssc_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rise_i,
    input  logic          lvl_i,
    input  logic          din_i,
    input  logic          copy_i,
    output logic [DW-1:0] sh_o,
    output logic [DW-1:0] buf_o,
    output logic          pin_o
);
    logic [DW-1:0] sh_q;
    logic [DW-1:0] sh_nxt;
    logic [DW-1:0] buf_q;
    logic          lat_q;

    // Next shift value: a write wins over the sampling edge.
    always_comb begin
        if (wr_i)        sh_nxt = wdata_i;
        else if (rise_i) sh_nxt = {sh_q[DW-2:0], din_i};
        else             sh_nxt = sh_q;
    end

    // Shift register, buffer copy and the transparent-low latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            buf_q <= '0;
            lat_q <= 1'b0;
        end else begin
            sh_q <= sh_nxt;
            if (copy_i) buf_q <= sh_nxt;
            if (!lvl_i) lat_q <= sh_q[DW-1];
        end
    end

    assign sh_o  = sh_q;
    assign buf_o = buf_q;
    assign pin_o = lvl_i ? lat_q : sh_q[DW-1];

    a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_i |=> (!lvl_i || $stable(pin_o)));

    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !wr_i) |=> (sh_o == {$past(sh_o[DW-2:0]), $past(din_i)}));

endmodule

// File: rtl/ssc_counter.sv
// Edge counter with overflow flag. Priority: status write, then start
// clear, then clock edge.
module ssc_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_i,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [CW-1:0] wcnt_i,
    input  logic          w1c_i,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o,
    output logic          wrap_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q;
    logic          ovf_q;

    // A wrap happens only when no higher-priority action is present.
    assign wrap_o = ev_i && (cnt_q == CNT_MAX) && !wr_i && !clr_i;

    // Counter and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_i)       cnt_q <= wcnt_i;
            else if (clr_i) cnt_q <= '0;
            else if (ev_i)  cnt_q <= cnt_q + 1'b1;
            if (wr_i)        ovf_q <= ovf_q & ~w1c_i;
            else if (wrap_o) ovf_q <= 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !wr_i && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

    a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && cnt_o == CNT_MAX && !wr_i && !clr_i) |=> ovf_o);

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wcnt_i)));

endmodule

// File: rtl/ssc_start.sv
// Start-condition detector for two-wire mode: the data line falls while
// the clock line is high. Assumes the line levels are synchronous to clk.
module ssc_start (
    input  logic clk,
    input  logic rst_n,
    input  logic two_wire_i,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_i,
    input  logic w1c_i,
    output logic start_o,
    output logic det_o
);
    logic sda_q;
    logic flag_q;

    assign det_o = two_wire_i && scl_i && sda_q && !sda_i;

    // Previous data level and the start flag; a status write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q  <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            sda_q <= sda_i;
            if (wr_i)       flag_q <= flag_q & ~w1c_i;
            else if (det_o) flag_q <= 1'b1;
        end
    end

    assign start_o = flag_q;

    a_r9_start_set: assert property (@(posedge clk) disable iff (!rst_n)
        (two_wire_i && scl_i && !sda_i && $past(sda_i) && !wr_i) |=> start_o);

endmodule

// File: rtl/ssc_top.sv
// Serial shift engine top. It holds the control register, decodes the
// write port and picks the clock source, then routes the data pin to the
// three-wire or two-wire outputs and builds the clock-hold.
// Assumes one write per cycle and pins that are synchronous to clk.
module ssc_top
    import ssc_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          tmr_match_i,
    input  logic          sclk_i,
    input  logic          din_i,
    input  logic          sda_i,
    output logic          sclk_o,
    output logic          sclk_pull_o,
    output logic          dout_o,
    output logic          sda_pull_o,
    output logic [DW-1:0] data_o,
    output logic [DW-1:0] buf_o,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o,
    output logic          start_o,
    output logic          irq_ovf_o,
    output logic          irq_start_o
);
    localparam int OVF_CLR_BIT   = DW - 2;
    localparam int START_CLR_BIT = DW - 1;

    ctrl_t ctrl_q;
    logic  wr_data, wr_stat, wr_ctrl, wr_strb;
    logic  ext_sel, strobe_src, tick;
    logic  lvl, rise, fall, ev;
    logic  din_sel, pin, wrap, det, hold;

    assign wr_data = wr_i && (addr_i == ADDR_DATA);
    assign wr_stat = wr_i && (addr_i == ADDR_STAT);
    assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
    assign wr_strb = wr_i && (addr_i == ADDR_STRB);

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end

    // Clock source selection.
    always_comb begin
        ext_sel    = (ctrl_q.src == SRC_PIN);
        strobe_src = (ctrl_q.src == SRC_STROBE) || (ctrl_q.src == SRC_STROBE_ALT);
        tick       = ((ctrl_q.src == SRC_TIMER) && tmr_match_i) || (strobe_src && wr_strb);
        din_sel    = ctrl_q.two_wire ? sda_i : din_i;
    end

    ssc_clkgen u_clk (
        .clk(clk), .rst_n(rst_n), .ext_sel_i(ext_sel), .pin_i(sclk_i),
        .tick_i(tick), .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    assign ev = rise | fall;

    ssc_shifter #(.DW(DW)) u_sh (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_data), .wdata_i(wdata_i),
        .rise_i(rise), .lvl_i(lvl), .din_i(din_sel), .copy_i(wrap),
        .sh_o(data_o), .buf_o(buf_o), .pin_o(pin)
    );

    ssc_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .clr_i(det), .wr_i(wr_stat),
        .wcnt_i(wdata_i[CW-1:0]), .w1c_i(wdata_i[OVF_CLR_BIT]),
        .cnt_o(cnt_o), .ovf_o(ovf_o), .wrap_o(wrap)
    );

    ssc_start u_st (
        .clk(clk), .rst_n(rst_n), .two_wire_i(ctrl_q.two_wire), .scl_i(sclk_i),
        .sda_i(sda_i), .wr_i(wr_stat), .w1c_i(wdata_i[START_CLR_BIT]),
        .start_o(start_o), .det_o(det)
    );

    // Pin routing, clock hold and interrupts.
    always_comb begin
        hold        = ctrl_q.two_wire && (start_o || (ctrl_q.hold_ovf && ovf_o));
        sclk_pull_o = hold || (ctrl_q.two_wire && !ext_sel && !lvl);
        sclk_o      = !ctrl_q.two_wire && !ext_sel && lvl;
        dout_o      = !ctrl_q.two_wire && pin;
        sda_pull_o  = ctrl_q.two_wire && !pin;
        irq_ovf_o   = ovf_o && ctrl_q.ovf_ie;
        irq_start_o = start_o && ctrl_q.start_ie;
    end

    a_r10_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_pull_o && start_o && !wr_ctrl && !(wr_stat && wdata_i[START_CLR_BIT]))
        |=> sclk_pull_o);

    a_r6_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strb && ctrl_q.src == SRC_TIMER && !tmr_match_i && !ctrl_q.two_wire)
        |=> $stable(cnt_o));

endmodule

// File: tb/sim_ssc_top.sv
`timescale 1ns/1ps
module sim_ssc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wdata_i = 8'd0;
    logic       tmr_match_i = 1'b0;
    logic       sclk_i = 1'b0;
    logic       din_i = 1'b0;
    logic       sda_i = 1'b1;
    logic       sclk_o, sclk_pull_o, dout_o, sda_pull_o;
    logic [7:0] data_o, buf_o;
    logic [3:0] cnt_o;
    logic       ovf_o, start_o, irq_ovf_o, irq_start_o;

    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;
    logic [7:0] exp_q[$];
    logic [7:0] sh = 8'd0;
    logic       ovf_prev = 1'b0;

    always #2.5 clk = ~clk;

    ssc_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .tmr_match_i(tmr_match_i), .sclk_i(sclk_i), .din_i(din_i), .sda_i(sda_i),
        .sclk_o(sclk_o), .sclk_pull_o(sclk_pull_o), .dout_o(dout_o),
        .sda_pull_o(sda_pull_o), .data_o(data_o), .buf_o(buf_o), .cnt_o(cnt_o),
        .ovf_o(ovf_o), .start_o(start_o), .irq_ovf_o(irq_ovf_o),
        .irq_start_o(irq_start_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic tpulse();
        tmr_match_i = 1'b1;
        @(negedge clk);
        tmr_match_i = 1'b0;
    endtask

    // Byte through the clock pin; data out checked at each edge (R3, R4).
    task automatic send_pin(input logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic old;
            din_i = rx[i];
            old = sh[7];
            sclk_i = 1'b1;
            @(negedge clk);
            sh = {sh[6:0], rx[i]};
            check("R3 pin holds after rise", dout_o, old);
            @(negedge clk);
            check("R3 pin holds while high", dout_o, old);
            if (i == 0) exp_q.push_back(sh);
            sclk_i = 1'b0;
            @(negedge clk);
            check("R4 dout follows MSB after fall", dout_o, sh[7]);
            @(negedge clk);
        end
    endtask

    // Byte through strobe writes (R6, R7).
    task automatic send_strobe(input logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            din_i = rx[i];
            wr(2'd3, 8'd0);
            sh = {sh[6:0], rx[i]};
            if (i == 7) check("R7 sclk_o high after strobe", sclk_o, 1'b1);
            if (i == 0) exp_q.push_back(sh);
            wr(2'd3, 8'd0);
            if (i == 7) check("R7 sclk_o low after strobe", sclk_o, 1'b0);
        end
    endtask

    // Byte through timer pulses (R6).
    task automatic send_timer(input logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            din_i = rx[i];
            tpulse();
            sh = {sh[6:0], rx[i]};
            if (i == 0) exp_q.push_back(sh);
            tpulse();
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Scoreboard monitor: each new overflow pops the expected buffer byte (R5).
    always @(negedge clk) begin
        if (rst_n) begin
            if (ovf_o && !ovf_prev) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5 unexpected overflow: actual buf %0h expected none", buf_o);
                end else begin
                    check("R5 buffer byte", buf_o, exp_q.pop_front());
                end
            end
        end
        ovf_prev = ovf_o;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 data reset", data_o, 8'h00);
        check("R1 buffer reset", buf_o, 8'h00);
        check("R1 counter reset", cnt_o, 4'h0);
        check("R1 flags reset", {ovf_o, start_o, irq_ovf_o, irq_start_o}, 4'h0);
        check("R1 pins reset", {sclk_o, sclk_pull_o, dout_o, sda_pull_o}, 4'h0);

        // Three-wire, pin clock, overflow interrupt enabled.
        wr(2'd2, 8'h08);
        wr(2'd0, 8'hA5); sh = 8'hA5;
        check("R2 direct write", data_o, 8'hA5);
        check("R4 dout shows MSB", dout_o, 1'b1);
        check("R4 no sda pull in three-wire", sda_pull_o, 1'b0);
        send_pin(8'h3C);
        check("R2 received byte in register", data_o, 8'h3C);
        check("R5 overflow flag", ovf_o, 1'b1);
        check("R5 overflow irq", irq_ovf_o, 1'b1);
        check("R5 counter wrapped", cnt_o, 4'h0);
        wr(2'd1, 8'h40);
        check("R8 overflow cleared", ovf_o, 1'b0);
        check("R8 irq cleared", irq_ovf_o, 1'b0);

        // Strobe source.
        wr(2'd2, 8'h0C);
        wr(2'd0, 8'h5A); sh = 8'h5A;
        send_strobe(8'hC3);
        check("R5 strobe overflow", ovf_o, 1'b1);
        wr(2'd1, 8'h40);

        // Timer source; strobes ignored.
        wr(2'd2, 8'h0A);
        wr(2'd3, 8'h00);
        check("R6 strobe ignored in timer mode", cnt_o, 4'h0);
        check("R6 strobe leaves register", data_o, sh);
        send_timer(8'h96);
        check("R5 timer overflow", ovf_o, 1'b1);
        check("R2 timer byte", data_o, 8'h96);
        wr(2'd1, 8'h40);

        // R8 priority: status write with a timer pulse in the same cycle.
        din_i = 1'b0;
        tmr_match_i = 1'b1; wr_i = 1'b1; addr_i = 2'd1; wdata_i = 8'h09;
        @(negedge clk);
        tmr_match_i = 1'b0; wr_i = 1'b0;
        sh = {sh[6:0], 1'b0};
        check("R8 write beats clock edge", cnt_o, 4'h9);
        tpulse();
        check("R5 counter step", cnt_o, 4'hA);

        // Counter preset, wrap after two edges.
        wr(2'd1, 8'h0E);
        din_i = 1'b1;
        tpulse();
        sh = {sh[6:0], 1'b1};
        exp_q.push_back(sh);
        tpulse();
        check("R5 preset wrap flag", ovf_o, 1'b1);
        check("R5 preset wrap counter", cnt_o, 4'h0);
        wr(2'd1, 8'h40);

        // Two-wire, start detection.
        sclk_i = 1'b1; sda_i = 1'b1; din_i = 1'b0;
        @(negedge clk);
        wr(2'd2, 8'h11);
        wr(2'd1, 8'h05);
        sclk_i = 1'b0;
        @(negedge clk);
        sda_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 no start while clock low", start_o, 1'b0);
        sda_i = 1'b1;
        @(negedge clk);
        sclk_i = 1'b1;
        @(negedge clk);
        sda_i = 1'b0;
        @(negedge clk);
        check("R9 start flag", start_o, 1'b1);
        check("R9 start irq", irq_start_o, 1'b1);
        check("R9 counter cleared", cnt_o, 4'h0);
        check("R10 clock held on start", sclk_pull_o, 1'b1);
        @(negedge clk);
        check("R10 hold persists", sclk_pull_o, 1'b1);
        wr(2'd1, 8'h80);
        check("R8 start cleared", start_o, 1'b0);
        check("R10 hold released", sclk_pull_o, 1'b0);
        sclk_i = 1'b0;
        @(negedge clk);
        wr(2'd0, 8'h00);
        check("R4 sda pulled for zero", sda_pull_o, 1'b1);
        check("R4 dout idle in two-wire", dout_o, 1'b0);
        wr(2'd0, 8'h80); sh = 8'h80;
        check("R4 sda released for one", sda_pull_o, 1'b0);

        // Two-wire hold on overflow.
        sda_i = 1'b1;
        @(negedge clk);
        wr(2'd2, 8'h21);
        wr(2'd1, 8'h0F);
        sh = {sh[6:0], 1'b1};
        exp_q.push_back(sh);
        sclk_i = 1'b1;
        @(negedge clk);
        check("R10 clock held on overflow", sclk_pull_o, 1'b1);
        check("R5 irq masked", irq_ovf_o, 1'b0);
        check("R2 sampled from sda", data_o, 8'h01);
        wr(2'd1, 8'h40);
        check("R10 overflow hold released", sclk_pull_o, 1'b0);

        @(negedge clk);
        check("R5 all buffer bytes seen", exp_q.size(), 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule